// File: doc/BRIEF.md
# I2C Paged Memory Target

This block is an I2C target that fronts a 256-byte memory built from registers and made to behave like an electrically erasable array. A controller opens a transfer with the 7-bit target address, sends a command byte and then one word-address byte. In a write transfer, the data bytes that follow go into a 16-byte staging page. That page is copied into the array only when the controller ends the transfer with STOP. The copy opens a timed busy window, during which the target ignores every request.

A read transfer starts with the same three bytes as a write. The controller then issues a repeated START with the read bit set, and the target streams array bytes out MSB first. The pointer is a full 8-bit counter that advances after every byte, so one transfer can walk the whole array and wrap from the last byte to the first. Writes behave differently: only the low four address bits move, and a burst stays inside its page. The SCL and SDA inputs pass through two-flop synchronizers. The target pulls SDA low through a single pull-low output, and the wired-AND with the bus is done outside the block.

Top module: `i2c_eep_target`

## Requirements
- R1: After reset, sda_pull_o and busy_o are 0, and every one of the 256 array bytes reads back as 0xFF.
- R2: The target acknowledges an address byte only when its upper seven bits equal dev_addr_i. Bit 0 selects the direction: 0 means write, 1 means read. For any other address the target leaves SDA released for the rest of the transfer.
- R3: After a write-direction address, the target acknowledges the next byte only if it equals CMD_CODE (default 0x20). Any other value is not acknowledged and ends the transfer. The word-address byte that follows a valid command is acknowledged, and so is every data byte.
- R4: Bits 7:4 of the word address choose one of 16 pages, and bits 3:0 give the first offset inside that page. After each data byte only the offset advances, going from 15 back to 0 within the same page.
- R5: If a burst carries more than 16 data bytes, the bytes that wrap around replace the earlier ones at the same offsets. Array bytes outside the addressed page stay unchanged.
- R6: Staged bytes are written to the array only on STOP, and only at the offsets that received data. A START or repeated START seen before that STOP throws the staged bytes away. A transfer that was refused (R2, R3) writes nothing and starts no busy window.
- R7: A STOP that writes to the array raises busy_o within a few clocks and holds it for BUSY_CYCLES clocks. While busy_o is high, the target does not acknowledge its own address.
- R8: A read uses the write preamble (address, command, word address), then a repeated START with the read bit. The target sends the byte at the pointer MSB first and adds 1 to the full 8-bit pointer after each byte, wrapping from 0xFF to 0x00.
- R9: When the controller does not acknowledge a read byte, the target stops sending and keeps SDA released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, used to sample both bus lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level as seen on the bus |
| sda_i | input | 1 | SDA level as seen on the bus |
| dev_addr_i | input | 7 | 7-bit target address this block answers to |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| busy_o | output | 1 | High while the array write window runs |

## Verification
A wrong transfer state or a wrong byte counter appears at once as a misplaced acknowledge. The error is visible on the ninth clock of the same byte, or as SDA being pulled while the controller is driving. A wrong pointer update cannot be seen in that same byte. It appears on the next byte read out, or, for writes, only after the busy window, when that page is read back. The bench therefore compares every streamed byte against a model kept in the bench itself. A wrong busy counter shows as a window of the wrong length, measured in clocks from the STOP, or as an acknowledge given while the window is still running.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_WADDR,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[SYNC_N-1];
  assign sda_s      = sda_ff[SYNC_N-1];
  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges with SCL held high on both samples
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  clr_i,
  input  logic                                  wr_en_i,
  input  logic [PAGE_W-1:0]                     wr_off_i,
  input  logic [DATA_W-1:0]                     wr_data_i,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]     data_o,
  output logic [PAGE_BYTES-1:0]                 mask_o
);
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[i] <= '0;
        mask_o[i] <= 1'b0;
      end else if (clr_i) begin
        mask_o[i] <= 1'b0;
      end else if (wr_en_i && wr_off_i == PAGE_W'(i)) begin
        data_o[i] <= wr_data_i;
        mask_o[i] <= 1'b1;
      end
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mask_o == '0)); // R6
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PG_W = ADDR_W - PAGE_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              commit_i,
  input  logic [PG_W-1:0]                   page_i,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_i,
  input  logic [PAGE_BYTES-1:0]             mask_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [DATA_W-1:0]                 rd_data_o
);
  logic [DATA_W-1:0] word_w [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    localparam logic [PG_W-1:0]   PG  = PG_W'(a >> PAGE_W);
    localparam logic [PAGE_W-1:0] OFF = PAGE_W'(a % PAGE_BYTES);
    logic [DATA_W-1:0] word_q;

    // whole page lands in one cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '1;
      else if (commit_i && page_i == PG && mask_i[OFF]) word_q <= buf_i[OFF];
    end
    assign word_w[a] = word_q;
  end

  assign rd_data_o = word_w[rd_addr_i];
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int BUSY_CYCLES = 200000,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R7
endmodule

// File: rtl/i2c_eep_target.sv
module i2c_eep_target
  import i2c_eep_pkg::*;
#(
  parameter int          PAGE_W      = 4,
  parameter logic [7:0]  CMD_CODE    = 8'h20,
  parameter int          BUSY_CYCLES = 200000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] dev_addr_i,
  output logic       sda_pull_o,
  output logic       busy_o
);
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BCNT_W     = $clog2(DATA_W + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  phase_e              ph;
  byte_kind_e          kind, nxt_kind;
  logic [DATA_W-1:0]   sh;
  logic [BCNT_W-1:0]   bcnt;
  logic                pull, to_tx, mack_ok;
  logic [ADDR_W-1:0]   ptr;
  logic [DATA_W-1:0]   rd_data;
  logic                byte_done, tx_done, ack_now, go_tx, ptr_load, wr_fire, commit;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] pg_data;
  logic [PAGE_BYTES-1:0]             pg_mask;

  assign byte_done = (ph == PH_RX) && scl_fall && (bcnt == BCNT_W'(DATA_W));
  assign tx_done   = (ph == PH_TX) && scl_fall && (bcnt == BCNT_W'(DATA_W));

  always_comb begin
    ack_now  = 1'b0;
    go_tx    = 1'b0;
    ptr_load = 1'b0;
    nxt_kind = kind;
    unique case (kind)
      BK_ADDR: if (sh[7:1] == dev_addr_i && !busy_o) begin
        ack_now = 1'b1;
        if (sh[0]) go_tx = 1'b1;
        else nxt_kind = BK_CMD;
      end
      BK_CMD: if (sh == CMD_CODE) begin
        ack_now  = 1'b1;
        nxt_kind = BK_WADDR;
      end
      BK_WADDR: begin
        ack_now  = 1'b1;
        ptr_load = 1'b1;
        nxt_kind = BK_DATA;
      end
      BK_DATA: ack_now = 1'b1;
      default: ;
    endcase
  end

  assign wr_fire = byte_done && (kind == BK_DATA);
  assign commit  = stop_det && (pg_mask != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph      <= PH_IDLE;
      kind    <= BK_ADDR;
      sh      <= '0;
      bcnt    <= '0;
      pull    <= 1'b0;
      to_tx   <= 1'b0;
      mack_ok <= 1'b0;
      ptr     <= '0;
    end else if (start_det) begin
      ph   <= PH_RX;
      kind <= BK_ADDR;
      bcnt <= '0;
      pull <= 1'b0;
    end else if (stop_det) begin
      ph   <= PH_IDLE;
      pull <= 1'b0;
    end else begin
      unique case (ph)
        PH_RX: begin
          if (scl_rise) begin
            sh   <= {sh[DATA_W-2:0], sda_s};
            bcnt <= bcnt + 1'b1;
          end else if (byte_done) begin
            if (ack_now) begin
              pull  <= 1'b1;
              ph    <= PH_ACK;
              kind  <= nxt_kind;
              to_tx <= go_tx;
              if (ptr_load) ptr <= sh;
              if (wr_fire) ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
            end else begin
              ph <= PH_IDLE;
            end
          end
        end
        PH_ACK: if (scl_fall) begin
          bcnt <= '0;
          if (to_tx) begin
            sh   <= rd_data;
            pull <= ~rd_data[DATA_W-1];
            ph   <= PH_TX;
          end else begin
            pull <= 1'b0;
            ph   <= PH_RX;
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            bcnt <= bcnt + 1'b1;
          end else if (tx_done) begin
            pull <= 1'b0;
            ph   <= PH_MACK;
            ptr  <= ptr + 1'b1;
          end else if (scl_fall) begin
            pull <= ~sh[DATA_W-2];
            sh   <= {sh[DATA_W-2:0], 1'b0};
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_ok) begin
              sh   <= rd_data;
              pull <= ~rd_data[DATA_W-1];
              bcnt <= '0;
              ph   <= PH_TX;
            end else begin
              ph <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull;

  eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_page (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_det | stop_det),
    .wr_en_i   (wr_fire),
    .wr_off_i  (ptr[PAGE_W-1:0]),
    .wr_data_i (sh),
    .data_o    (pg_data),
    .mask_o    (pg_mask)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .page_i    (ptr[ADDR_W-1:PAGE_W]),
    .buf_i     (pg_data),
    .mask_i    (pg_mask),
    .rd_addr_i (ptr),
    .rd_data_o (rd_data)
  );

  eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (busy_o)
  );

  AST_BUSY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_pull_o); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_IDLE) |-> !sda_pull_o); // R9
  AST_PAGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))
             && (ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1))); // R4
  AST_READ_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R8
endmodule

// File: tb/tb_i2c_eep_target.sv
module tb_i2c_eep_target;
  localparam int         BUSY = 3000;
  localparam int         Q    = 10;
  localparam logic [6:0] DEV  = 7'h50;
  localparam logic [7:0] CMD  = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, busy;
  wire  sda_line = m_sda & ~sda_pull;

  i2c_eep_target #(.PAGE_W(4), .CMD_CODE(CMD), .BUSY_CYCLES(BUSY)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .dev_addr_i (DEV),
    .sda_pull_o (sda_pull),
    .busy_o     (busy)
  );

  int checks = 0, errors = 0, cyc = 0, t_stop = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] exp_q[$], act_q[$], wq[$];
  string      tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops produced bytes against expected ones
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a == e, t, a, e);
      end
    end
  end

  task automatic i2c_start();
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(Q);
      m_scl = 1'b1; hold(2 * Q);
      m_scl = 1'b0; hold(Q);
    end
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    ack = ~sda_line; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic read_byte(input bit mack);
    logic [7:0] b;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      m_scl = 1'b1; hold(Q);
      b[i] = sda_line; hold(Q);
      m_scl = 1'b0;
    end
    hold(Q);
    m_sda = ~mack; hold(Q);
    m_scl = 1'b1; hold(2 * Q);
    m_scl = 1'b0; hold(Q);
    m_sda = 1'b1;
    act_q.push_back(b);
  endtask

  task automatic preamble(input logic [7:0] waddr);
    bit a;
    i2c_start();
    write_byte({DEV, 1'b0}, a); check(a, "R2 address ack", a, 1);
    write_byte(CMD, a);         check(a, "R3 command ack", a, 1);
    write_byte(waddr, a);       check(a, "R3 word address ack", a, 1);
  endtask

  // writes wq starting at waddr, then STOP; model applies page wrap
  task automatic wr_txn(input logic [7:0] waddr);
    bit a;
    logic [3:0] off;
    preamble(waddr);
    foreach (wq[k]) begin
      write_byte(wq[k], a); check(a, "R3 data ack", a, 1);
    end
    i2c_stop();
    t_stop = cyc;
    off = waddr[3:0];
    foreach (wq[k]) begin
      ref_mem[{waddr[7:4], off}] = wq[k];
      off = off + 1'b1;
    end
  endtask

  task automatic wait_ready();
    int el;
    while (busy) hold(1);
    el = cyc - t_stop;
    check(el >= BUSY - 20 && el <= BUSY, "R7 busy window length", el, BUSY);
  endtask

  task automatic rd_txn(input logic [7:0] waddr, input int n, input string tag);
    bit a;
    logic [7:0] p;
    preamble(waddr);
    i2c_start();
    write_byte({DEV, 1'b1}, a); check(a, "R8 read address ack", a, 1);
    p = waddr;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(ref_mem[p]);
      tag_q.push_back(tag);
      read_byte(k != n - 1);
      p = p + 1'b1;
    end
    i2c_stop();
    hold(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    check(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
    check(busy == 1'b0, "R1 not busy", busy, 0);
    rd_txn(8'h00, 4, "R1 erased read");

    // R4: burst from mid-page
    wq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    wr_txn(8'h23);
    hold(5);
    check(busy == 1'b1, "R7 busy raised", busy, 1);
    i2c_start();
    write_byte({DEV, 1'b0}, a); check(!a, "R7 address nack while busy", a, 0);
    i2c_stop();
    wait_ready();
    rd_txn(8'h22, 6, "R4 page write data");

    // R5: 18 bytes wrap inside page 3
    wq = {};
    for (int k = 0; k < 18; k++) wq.push_back(8'(8'h40 + k));
    wr_txn(8'h3E);
    wait_ready();
    rd_txn(8'h2F, 18, "R5 overwrite on wrap");

    // R8: read wrap vs page wrap
    wq = '{8'h11, 8'h22, 8'h33};
    wr_txn(8'hFE);
    wait_ready();
    wq = '{8'h44};
    wr_txn(8'h00);
    wait_ready();
    rd_txn(8'hFD, 5, "R8 full address wrap");

    // R2: other target address
    i2c_start();
    write_byte({7'h51, 1'b0}, a); check(!a, "R2 foreign address nack", a, 0);
    write_byte(8'h00, a);         check(!a, "R2 silent after nack", a, 0);
    i2c_stop();

    // R3: bad command byte
    i2c_start();
    write_byte({DEV, 1'b0}, a); check(a, "R3 address ack", a, 1);
    write_byte(8'h21, a);       check(!a, "R3 bad command nack", a, 0);
    write_byte(8'h60, a);       check(!a, "R3 silent after bad command", a, 0);
    i2c_stop();
    hold(10);
    check(busy == 1'b0, "R6 refused transfer no busy", busy, 0);

    // R6: repeated START discards staged bytes
    preamble(8'h60);
    write_byte(8'hAA, a); check(a, "R3 data ack", a, 1);
    write_byte(8'hBB, a); check(a, "R3 data ack", a, 1);
    i2c_start();
    i2c_stop();
    hold(10);
    check(busy == 1'b0, "R6 aborted write no busy", busy, 0);
    rd_txn(8'h60, 2, "R6 aborted write not committed");

    // R9: after master NACK the target stays off the line
    preamble(8'h23);
    i2c_start();
    write_byte({DEV, 1'b1}, a); check(a, "R8 read address ack", a, 1);
    exp_q.push_back(ref_mem[8'h23]); tag_q.push_back("R9 byte before nack");
    read_byte(1'b1);
    exp_q.push_back(ref_mem[8'h24]); tag_q.push_back("R9 nacked byte");
    read_byte(1'b0);
    exp_q.push_back(8'hFF); tag_q.push_back("R9 released after nack");
    read_byte(1'b0);
    i2c_stop();

    hold(20);
    check(exp_q.size() == 0 && act_q.size() == 0, "scoreboard drained",
          act_q.size(), exp_q.size());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule